// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped cache. Each line the main cache throws out is offered to the buffer, together with its full block address (tag and index) and its data. The full address is kept because a buffered line may belong to any set of the main cache. When the main cache misses, the block address is presented on the lookup port. The buffer compares it against every stored entry in the same cycle and reports hit and data, so the request reaches lower memory only if the buffer also misses.

A lookup hit hands the line back to the main cache. The entry is taken out of the buffer, and its address and data leave on the swap port one cycle later. If the main cache evicts the line that sat at that index in the same cycle, that eviction goes into the freed slot. One access therefore exchanges the two lines. New lines fill the lowest free slot. Once every slot is in use, a wrapping replacement pointer chooses the entry to overwrite.

The swap port is driven by a two-state machine. `VB_IDLE` means no line is being handed back and `VB_FILL` means one is. Each cycle the machine goes to `VB_FILL` if the lookup hit in that cycle, and to `VB_IDLE` otherwise. The transitions are IDLE->FILL on a hit, FILL->FILL on back-to-back hits, FILL->IDLE when no hit follows, and IDLE->IDLE when idle.

Top module: `victim_buffer`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `sw_valid` is 0.
- R2: With `lk_valid` high and `lk_addr` equal to the address of a stored entry, `lk_hit` is 1 in the same cycle and `lk_data` carries that entry's data.
- R3: A lookup that hits a stored entry removes it at the clock edge, so the next lookup of the same address misses (unless it is inserted again).
- R4: While `lk_valid` is low, `lk_hit` is 0 and no entry is removed, even if `lk_addr` matches a stored entry.
- R5: A lookup that hits a stored entry while `ins_valid` is high (with a different address) is a swap: the hit line is returned and removed, and the inserted line is stored in its place and can be found by later lookups.
- R6: In the cycle after `lk_hit` is 1, `sw_valid` is 1 and `sw_addr`/`sw_data` carry the address and data returned by that lookup. In the cycle after `lk_hit` is 0, `sw_valid` is 0.
- R7: A plain insert (no swap, address not already stored) takes a free slot whenever one exists, so up to ENTRIES lines with distinct addresses are all retained.
- R8: With all ENTRIES slots valid, a plain insert overwrites the slot named by a replacement pointer and advances the pointer by one, wrapping from ENTRIES-1 to 0. The pointer is 0 after reset and moves only in that case. Free slots are taken lowest index first.
- R9: Inserting an address that is already stored overwrites that entry's data and does not occupy another slot.
- R10: A lookup and an insert of the same address in one cycle give `lk_hit` = 1 with `lk_data` equal to the inserted data. The line passes straight to the swap port and is not kept: afterwards that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An evicted line is offered this cycle |
| ins_addr | input | ADDR_W | Full block address of the evicted line |
| ins_data | input | DATA_W | Data of the evicted line |
| lk_valid | input | 1 | Main cache missed; search for `lk_addr` |
| lk_addr | input | ADDR_W | Block address being looked up |
| lk_hit | output | 1 | Lookup found the line (same cycle) |
| lk_data | output | DATA_W | Data of the found line (same cycle) |
| sw_valid | output | 1 | A line is handed back to the main cache |
| sw_addr | output | ADDR_W | Block address of the handed-back line |
| sw_data | output | DATA_W | Data of the handed-back line |

## Verification
The bench builds the buffer with ENTRIES = 4, a 12-bit block address and 32-bit data. With this depth, a few inserts fill the buffer, so the replacement pointer can be stepped through a wrap. The pointer can also be left at a nonzero position after removals, which lets the tests show that the slot that gets overwritten follows the pointer and not the age of the entries. The narrow address keeps the hand-computed expected lines readable, and every lookup result and swap-port beat is compared against a scoreboard queue.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Swap-port sequencing states
    typedef enum logic [0:0] {
        VB_IDLE = 1'b0,
        VB_FILL = 1'b1
    } vb_state_e;

endpackage

// File: rtl/vb_match.sv
// Fully associative compare: one comparator per entry, lowest index wins.
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 26
) (
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0][AW-1:0] tag_i,
    input  logic [AW-1:0]        key_i,
    output logic                 hit_o,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] sel_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    always_comb begin
        hit_o = |eq;
        sel_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                sel_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vb_alloc.sv
// Slot choice for a plain insert: lowest free slot, else the pointer slot.
module vb_alloc #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] valid_i,
    input  logic         take_i,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] slot_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;
    logic          full;

    assign full = &valid_i;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IW'(i);
            end
        end
    end

    assign slot_o = full ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take_i && full) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R8
    ptr_moves_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> $past(&valid_i));

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              sw_valid,
    output logic [ADDR_W-1:0] sw_addr,
    output logic [DATA_W-1:0] sw_data
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;

    // Search results
    logic          lk_m_hit;
    logic [IW-1:0] lk_sel;
    logic          in_m_hit;
    logic [IW-1:0] in_sel;
    logic [IW-1:0] alloc_slot;

    // Access decode
    logic          fwd;
    logic          entry_hit;
    logic          ins_store;
    logic          plain_ins;
    logic [IW-1:0] tgt;

    // Swap-port state machine
    vb_state_e         state_q;
    vb_state_e         state_d;
    logic [ADDR_W-1:0] sw_addr_q;
    logic [DATA_W-1:0] sw_data_q;

    vb_match #(.N(ENTRIES), .AW(ADDR_W)) u_lk_match (
        .valid_i (valid_q),
        .tag_i   (tag_q),
        .key_i   (lk_addr),
        .hit_o   (lk_m_hit),
        .sel_o   (lk_sel)
    );

    vb_match #(.N(ENTRIES), .AW(ADDR_W)) u_in_match (
        .valid_i (valid_q),
        .tag_i   (tag_q),
        .key_i   (ins_addr),
        .hit_o   (in_m_hit),
        .sel_o   (in_sel)
    );

    vb_alloc #(.N(ENTRIES)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_q),
        .take_i  (plain_ins),
        .slot_o  (alloc_slot)
    );

    always_comb begin
        fwd       = lk_valid && ins_valid && (ins_addr == lk_addr);
        entry_hit = lk_valid && lk_m_hit && !fwd;
        lk_hit    = fwd || entry_hit;
        lk_data   = fwd ? ins_data : data_q[lk_sel];
        ins_store = ins_valid && !fwd;
        plain_ins = ins_store && !in_m_hit && !entry_hit;
        if (in_m_hit) begin
            tgt = in_sel;
        end else if (entry_hit) begin
            tgt = lk_sel;
        end else begin
            tgt = alloc_slot;
        end
    end

    // Entry update: removal on lookup hit, then the insert (wins on the same slot)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (lk_valid && lk_m_hit) begin
                valid_q[lk_sel] <= 1'b0;
            end
            if (ins_store) begin
                valid_q[tgt] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_store) begin
            tag_q[tgt]  <= ins_addr;
            data_q[tgt] <= ins_data;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            VB_IDLE: state_d = lk_hit ? VB_FILL : VB_IDLE;
            VB_FILL: state_d = lk_hit ? VB_FILL : VB_IDLE;
            default: state_d = VB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (lk_hit) begin
            sw_addr_q <= lk_addr;
            sw_data_q <= lk_data;
        end
    end

    // Outputs
    always_comb begin
        sw_addr = sw_addr_q;
        sw_data = sw_data_q;
        unique case (state_q)
            VB_IDLE: sw_valid = 1'b0;
            VB_FILL: sw_valid = 1'b1;
            default: sw_valid = 1'b0;
        endcase
    end

    // Checks
    logic dup_any;
    always_comb begin
        dup_any = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (valid_q[i] && valid_q[j] && (tag_q[i] == tag_q[j])) begin
                    dup_any = 1'b1;
                end
            end
        end
    end

    // R9
    no_dup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_any);

    // R3
    hit_removes_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_m_hit && !ins_valid) |=>
            ($countones(valid_q) == $countones($past(valid_q)) - 1));

    // R6
    fill_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> sw_valid);

    // R6
    fill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (sw_addr == $past(lk_addr)) && (sw_data == $past(lk_data)));

endmodule

// File: tb/sim_victim_buffer.sv
module sim_victim_buffer;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic [DW-1:0] ins_data = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;
    logic          sw_valid;
    logic [AW-1:0] sw_addr;
    logic [DW-1:0] sw_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [AW+DW-1:0] expq[$];

    always #2 clk = ~clk;

    victim_buffer #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk, .rst_n, .ins_valid, .ins_addr, .ins_data,
        .lk_valid, .lk_addr, .lk_hit, .lk_data,
        .sw_valid, .sw_addr, .sw_data
    );

    function automatic logic [DW-1:0] mk(input logic [AW-1:0] a, input logic [7:0] v);
        return {v, 12'h000, a};
    endfunction

    // Driver: one access per cycle; checks the same-cycle lookup result
    task automatic step(input logic lv, input logic [AW-1:0] la,
                        input logic iv, input logic [AW-1:0] ia, input logic [DW-1:0] id,
                        input logic eh, input logic [DW-1:0] ed, input string req);
        @(negedge clk);
        lk_valid = lv; lk_addr = la;
        ins_valid = iv; ins_addr = ia; ins_data = id;
        #1;
        nchk++;
        if (lk_hit !== eh) begin
            nfail++;
            $display("FAIL %s: lk_hit for addr %h = %b, expected %b", req, la, lk_hit, eh);
        end else if (eh && (lk_data !== ed)) begin
            nfail++;
            $display("FAIL %s: lk_data for addr %h = %h, expected %h", req, la, lk_data, ed);
        end
        if (eh) expq.push_back({la, ed});
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        step(1'b0, '0, 1'b1, a, d, 1'b0, '0, req);
    endtask

    task automatic look(input logic [AW-1:0] a, input logic eh, input logic [DW-1:0] ed,
                        input string req);
        step(1'b1, a, 1'b0, '0, '0, eh, ed, req);
    endtask

    // Monitor: swap-port beats against the scoreboard queue (R6)
    initial begin
        logic [AW+DW-1:0] e;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && (sw_valid || expq.size() > 0)) begin
                nchk++;
                if (!sw_valid) begin
                    nfail++;
                    $display("FAIL R6: sw_valid = 0, expected 1");
                    void'(expq.pop_front());
                end else if (expq.size() == 0) begin
                    nfail++;
                    $display("FAIL R6: sw_valid = 1, expected 0");
                end else begin
                    e = expq.pop_front();
                    if ({sw_addr, sw_data} !== e) begin
                        nfail++;
                        $display("FAIL R6: swap line %h/%h, expected %h/%h",
                                 sw_addr, sw_data, e[AW+DW-1:DW], e[DW-1:0]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        nchk++;
        if (sw_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1: sw_valid = %b, expected 0", sw_valid);
        end
        look(12'h010, 1'b0, '0, "R1");

        // R2 / R3: store, hit, then gone
        put(12'h010, mk(12'h010, 8'h01), "R2");
        look(12'h010, 1'b1, mk(12'h010, 8'h01), "R2");
        look(12'h010, 1'b0, '0, "R3");

        // R4: lookup strobe low leaves the entry in place
        put(12'h020, mk(12'h020, 8'h02), "R4");
        step(1'b0, 12'h020, 1'b0, '0, '0, 1'b0, '0, "R4");
        look(12'h020, 1'b1, mk(12'h020, 8'h02), "R4");

        // R7 / R8: fill four slots, then two replacements from pointer 0
        put(12'h101, mk(12'h101, 8'h11), "R7");
        put(12'h102, mk(12'h102, 8'h12), "R7");
        put(12'h103, mk(12'h103, 8'h13), "R7");
        put(12'h104, mk(12'h104, 8'h14), "R7");
        put(12'h105, mk(12'h105, 8'h15), "R8");
        put(12'h106, mk(12'h106, 8'h16), "R8");
        look(12'h101, 1'b0, '0, "R8");
        look(12'h102, 1'b0, '0, "R8");
        look(12'h103, 1'b1, mk(12'h103, 8'h13), "R7");
        look(12'h104, 1'b1, mk(12'h104, 8'h14), "R7");
        look(12'h105, 1'b1, mk(12'h105, 8'h15), "R8");
        look(12'h106, 1'b1, mk(12'h106, 8'h16), "R8");

        // R9: re-insert updates in place; four distinct lines still fit
        put(12'h201, mk(12'h201, 8'h21), "R9");
        put(12'h202, mk(12'h202, 8'h22), "R9");
        put(12'h203, mk(12'h203, 8'h23), "R9");
        put(12'h201, mk(12'h201, 8'h29), "R9");
        put(12'h204, mk(12'h204, 8'h24), "R9");
        look(12'h201, 1'b1, mk(12'h201, 8'h29), "R9");
        look(12'h202, 1'b1, mk(12'h202, 8'h22), "R9");
        look(12'h203, 1'b1, mk(12'h203, 8'h23), "R9");
        look(12'h204, 1'b1, mk(12'h204, 8'h24), "R9");

        // R5: swap in one access
        put(12'h301, mk(12'h301, 8'h31), "R5");
        step(1'b1, 12'h301, 1'b1, 12'h302, mk(12'h302, 8'h32), 1'b1, mk(12'h301, 8'h31), "R5");
        look(12'h301, 1'b0, '0, "R5");
        look(12'h302, 1'b1, mk(12'h302, 8'h32), "R5");

        // R10: same-address lookup and insert
        put(12'h401, mk(12'h401, 8'h41), "R10");
        step(1'b1, 12'h401, 1'b1, 12'h401, mk(12'h401, 8'h42), 1'b1, mk(12'h401, 8'h42), "R10");
        look(12'h401, 1'b0, '0, "R10");
        step(1'b1, 12'h402, 1'b1, 12'h402, mk(12'h402, 8'h43), 1'b1, mk(12'h402, 8'h43), "R10");
        look(12'h402, 1'b0, '0, "R10");

        // R8: pointer now at 2, so slots 2 and 3 are overwritten
        put(12'h501, mk(12'h501, 8'h51), "R8");
        put(12'h502, mk(12'h502, 8'h52), "R8");
        put(12'h503, mk(12'h503, 8'h53), "R8");
        put(12'h504, mk(12'h504, 8'h54), "R8");
        put(12'h505, mk(12'h505, 8'h55), "R8");
        put(12'h506, mk(12'h506, 8'h56), "R8");
        look(12'h503, 1'b0, '0, "R8");
        look(12'h504, 1'b0, '0, "R8");
        look(12'h501, 1'b1, mk(12'h501, 8'h51), "R8");
        look(12'h502, 1'b1, mk(12'h502, 8'h52), "R8");
        look(12'h505, 1'b1, mk(12'h505, 8'h55), "R8");
        look(12'h506, 1'b1, mk(12'h506, 8'h56), "R8");

        // drain, R6 idle check on the swap port
        step(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, "R6");
        step(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, "R6");
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule